// File: doc/BRIEF.md
# Viewport and Overscan Border Calculator

This block takes a set of scaler settings, namely a source viewport, a pixel format flag, the active raster size, the placement of the scaled output rectangle and a debug flag, and derives three things. The first is an even-aligned luma source window. The second is the matching chroma window. The third is the four overscan border widths around the output rectangle.

The settings are sampled on a one-cycle load strobe. A small state machine computes the results in one registered step and then raises a one-cycle done pulse. Between loads the results hold.

A combinational marker compares a raster position (`scan_x`, `scan_y`) against the stored borders and flags every pixel that falls in the overscan border. This marker is what a downstream pixel pipe uses to select border colour. Fetching pixels and filtering are handled elsewhere.

The state machine has three states. `ST_IDLE` waits for `load`. On `load` it moves to `ST_CALC` (transition *capture*), and the settings are registered. `ST_CALC` always moves to `ST_DONE` (transition *commit*), and the results are registered. `ST_DONE` always returns to `ST_IDLE` (transition *finish*). A `load` seen outside `ST_IDLE` is dropped.

Top module: `vp_border_calc`

## Requirements
- R1: Each luma output (x, y, width, height) equals the matching captured viewport input with bit 0 cleared.
- R2: When `fmt_420` is 0, each chroma output equals the matching luma output.
- R3: When `fmt_420` is 1, each chroma output equals the matching aligned luma value shifted right by one.
- R4: `edge_left` equals the captured `out_x`, and `edge_top` equals the captured `out_y`.
- R5: `edge_right` is `act_w - out_x - out_w`, and `edge_bottom` is `act_h - out_y - out_h`.
- R6: When `dbg_confirm` is 1, 2 is added to both the right border and the bottom border before the clamp.
- R7: A right or bottom result below zero is output as 0. In that case `clamp_flag` is 1 for that result; otherwise it is 0.
- R8: The luma outputs change only when both the aligned width and the aligned height are nonzero. The chroma outputs change only when both chroma width and chroma height are nonzero. Otherwise each set keeps its previous value. The borders update on every load.
- R9: A `load` that is high in `ST_IDLE` at a rising edge is captured. Results and `done` appear after the second rising edge after that. `done` is high for exactly one cycle. A `load` that arrives while a calculation is in progress is ignored.
- R10: `border_pix` is 1 exactly when `scan_x < edge_left`, or `scan_x >= act_w - edge_right`, or `scan_y < edge_top`, or `scan_y >= act_h - edge_bottom`. The comparisons are signed and use the captured active size.
- R11: After reset, every viewport and border output is 0, `clamp_flag` and `done` are 0, and the machine is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Strobe that samples the settings |
| fmt_420 | input | 1 | 1 = 4:2:0, 0 = RGB/4:4:4 |
| dbg_confirm | input | 1 | Debug flag, widens the right and bottom borders by 2 |
| vp_x | input | W | Viewport origin x |
| vp_y | input | W | Viewport origin y |
| vp_w | input | W | Viewport width |
| vp_h | input | W | Viewport height |
| act_w | input | W | Active width |
| act_h | input | W | Active height |
| out_x | input | W | Output rectangle x |
| out_y | input | W | Output rectangle y |
| out_w | input | W | Output rectangle width |
| out_h | input | W | Output rectangle height |
| scan_x | input | W | Raster x counter |
| scan_y | input | W | Raster y counter |
| luma_x | output | W | Aligned luma x |
| luma_y | output | W | Aligned luma y |
| luma_w | output | W | Aligned luma width |
| luma_h | output | W | Aligned luma height |
| chroma_x | output | W | Chroma x |
| chroma_y | output | W | Chroma y |
| chroma_w | output | W | Chroma width |
| chroma_h | output | W | Chroma height |
| edge_left | output | W | Left border |
| edge_right | output | W | Right border |
| edge_top | output | W | Top border |
| edge_bottom | output | W | Bottom border |
| clamp_flag | output | 1 | Last result needed a clamp |
| done | output | 1 | One-cycle completion pulse |
| border_pix | output | 1 | Raster position lies in the border |

## Verification
The assertions assume three things about the inputs. First, `load` is a one-cycle strobe. Second, `act_w` and `act_h` stay at least 3 below the full range of W bits, so that an unclamped border plus the debug widening still fits in W bits. Third, the raster counters stay within W bits.

Every scenario in the stimulus uses active sizes of at most 1920 by 1080 with W = 12. Each scenario pulses `load` for a single cycle, and waits for the machine to return to `ST_IDLE` before it starts the next load. The one exception is the deliberate busy-load scenario.

// File: rtl/vpb_pkg.sv
package vpb_pkg;
    localparam int VPB_CW = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } vpb_state_e;
endpackage

// File: rtl/vpb_align.sv
module vpb_align #(
    parameter int W = vpb_pkg::VPB_CW
) (
    input  logic [4*W-1:0] raw,      // {h, w, y, x}
    input  logic           half,
    output logic [4*W-1:0] luma,
    output logic [4*W-1:0] chroma,
    output logic           luma_ok,
    output logic           chroma_ok
);
    localparam int NF = 4;

    for (genvar f = 0; f < NF; f++) begin : g_field
        logic [W-1:0] even_v;
        assign even_v = {raw[f*W+1 +: W-1], 1'b0};
        assign luma[f*W +: W]   = even_v;
        assign chroma[f*W +: W] = half ? {1'b0, even_v[W-1:1]} : even_v;
    end

    assign luma_ok   = (luma[2*W +: W] != '0) && (luma[3*W +: W] != '0);
    assign chroma_ok = (chroma[2*W +: W] != '0) && (chroma[3*W +: W] != '0);
endmodule

// File: rtl/vpb_border.sv
module vpb_border #(
    parameter int W = vpb_pkg::VPB_CW
) (
    input  logic [W-1:0] act_w,
    input  logic [W-1:0] act_h,
    input  logic [W-1:0] out_x,
    input  logic [W-1:0] out_y,
    input  logic [W-1:0] out_w,
    input  logic [W-1:0] out_h,
    input  logic         widen,
    output logic [W-1:0] right,
    output logic [W-1:0] bottom,
    output logic         clamped
);
    localparam int S = W + 2;

    logic signed [S-1:0] r_raw, b_raw, pad;

    always_comb begin
        pad   = widen ? S'(2) : S'(0);
        r_raw = $signed({2'b00, act_w}) - $signed({2'b00, out_x})
              - $signed({2'b00, out_w}) + pad;
        b_raw = $signed({2'b00, act_h}) - $signed({2'b00, out_y})
              - $signed({2'b00, out_h}) + pad;
        right   = r_raw[S-1] ? '0 : r_raw[W-1:0];
        bottom  = b_raw[S-1] ? '0 : b_raw[W-1:0];
        clamped = r_raw[S-1] | b_raw[S-1];
    end
endmodule

// File: rtl/vpb_mark.sv
module vpb_mark #(
    parameter int W = vpb_pkg::VPB_CW
) (
    input  logic [W-1:0] act_w,
    input  logic [W-1:0] act_h,
    input  logic [W-1:0] left,
    input  logic [W-1:0] right,
    input  logic [W-1:0] top,
    input  logic [W-1:0] bottom,
    input  logic [W-1:0] sx,
    input  logic [W-1:0] sy,
    output logic         in_border
);
    localparam int S = W + 2;

    logic signed [S-1:0] x_lim, y_lim, xs, ys;

    always_comb begin
        x_lim = $signed({2'b00, act_w}) - $signed({2'b00, right});
        y_lim = $signed({2'b00, act_h}) - $signed({2'b00, bottom});
        xs    = $signed({2'b00, sx});
        ys    = $signed({2'b00, sy});
        in_border = (sx < left) || (xs >= x_lim) || (sy < top) || (ys >= y_lim);
    end
endmodule

// File: rtl/vp_border_calc.sv
module vp_border_calc #(
    parameter int W = vpb_pkg::VPB_CW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         fmt_420,
    input  logic         dbg_confirm,
    input  logic [W-1:0] vp_x,
    input  logic [W-1:0] vp_y,
    input  logic [W-1:0] vp_w,
    input  logic [W-1:0] vp_h,
    input  logic [W-1:0] act_w,
    input  logic [W-1:0] act_h,
    input  logic [W-1:0] out_x,
    input  logic [W-1:0] out_y,
    input  logic [W-1:0] out_w,
    input  logic [W-1:0] out_h,
    input  logic [W-1:0] scan_x,
    input  logic [W-1:0] scan_y,
    output logic [W-1:0] luma_x,
    output logic [W-1:0] luma_y,
    output logic [W-1:0] luma_w,
    output logic [W-1:0] luma_h,
    output logic [W-1:0] chroma_x,
    output logic [W-1:0] chroma_y,
    output logic [W-1:0] chroma_w,
    output logic [W-1:0] chroma_h,
    output logic [W-1:0] edge_left,
    output logic [W-1:0] edge_right,
    output logic [W-1:0] edge_top,
    output logic [W-1:0] edge_bottom,
    output logic         clamp_flag,
    output logic         done
    ,
    output logic         border_pix
);
    import vpb_pkg::*;

    localparam int RW = 4 * W;

    vpb_state_e state_q, state_d;

    // captured settings
    logic [RW-1:0] vp_q;
    logic          fmt_q, dbg_q;
    logic [W-1:0]  aw_q, ah_q, ox_q, oy_q, ow_q, oh_q;

    // committed results
    logic [RW-1:0] luma_q, chroma_q;
    logic [W-1:0]  left_q, right_q, top_q, bottom_q;
    logic          clamp_q;

    // combinational results
    logic [RW-1:0] luma_c, chroma_c;
    logic          luma_ok, chroma_ok;
    logic [W-1:0]  right_c, bottom_c;
    logic          clamp_c;
    logic          capture, commit;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load) state_d = ST_CALC;
            ST_CALC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the state
    always_comb begin
        capture = (state_q == ST_IDLE) && load;
        commit  = (state_q == ST_CALC);
        done    = (state_q == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vp_q  <= '0;
            fmt_q <= 1'b0;
            dbg_q <= 1'b0;
            ox_q  <= '0;
            oy_q  <= '0;
            ow_q  <= '0;
            oh_q  <= '0;
        end else if (capture) begin
            vp_q  <= {vp_h, vp_w, vp_y, vp_x};
            fmt_q <= fmt_420;
            dbg_q <= dbg_confirm;
            ox_q  <= out_x;
            oy_q  <= out_y;
            ow_q  <= out_w;
            oh_q  <= out_h;
        end
    end

    // the active size used by the marker changes together with the borders
    logic [W-1:0] aw_c, ah_c;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aw_c <= '0;
            ah_c <= '0;
        end else if (capture) begin
            aw_c <= act_w;
            ah_c <= act_h;
        end
    end

    vpb_align #(.W(W)) u_align (
        .raw       (vp_q),
        .half      (fmt_q),
        .luma      (luma_c),
        .chroma    (chroma_c),
        .luma_ok   (luma_ok),
        .chroma_ok (chroma_ok)
    );

    vpb_border #(.W(W)) u_border (
        .act_w   (aw_c),
        .act_h   (ah_c),
        .out_x   (ox_q),
        .out_y   (oy_q),
        .out_w   (ow_q),
        .out_h   (oh_q),
        .widen   (dbg_q),
        .right   (right_c),
        .bottom  (bottom_c),
        .clamped (clamp_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            luma_q   <= '0;
            chroma_q <= '0;
            left_q   <= '0;
            right_q  <= '0;
            top_q    <= '0;
            bottom_q <= '0;
            clamp_q  <= 1'b0;
            aw_q     <= '0;
            ah_q     <= '0;
        end else if (commit) begin
            if (luma_ok)   luma_q   <= luma_c;
            if (chroma_ok) chroma_q <= chroma_c;
            left_q   <= ox_q;
            top_q    <= oy_q;
            right_q  <= right_c;
            bottom_q <= bottom_c;
            clamp_q  <= clamp_c;
            aw_q     <= aw_c;
            ah_q     <= ah_c;
        end
    end

    vpb_mark #(.W(W)) u_mark (
        .act_w     (aw_q),
        .act_h     (ah_q),
        .left      (left_q),
        .right     (right_q),
        .top       (top_q),
        .bottom    (bottom_q),
        .sx        (scan_x),
        .sy        (scan_y),
        .in_border (border_pix)
    );

    assign luma_x      = luma_q[0 +: W];
    assign luma_y      = luma_q[W +: W];
    assign luma_w      = luma_q[2*W +: W];
    assign luma_h      = luma_q[3*W +: W];
    assign chroma_x    = chroma_q[0 +: W];
    assign chroma_y    = chroma_q[W +: W];
    assign chroma_w    = chroma_q[2*W +: W];
    assign chroma_h    = chroma_q[3*W +: W];
    assign edge_left   = left_q;
    assign edge_right  = right_q;
    assign edge_top    = top_q;
    assign edge_bottom = bottom_q;
    assign clamp_flag  = clamp_q;
endmodule

// File: rtl/vp_border_chk.sv
module vp_border_chk #(
    parameter int W = vpb_pkg::VPB_CW
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] luma_x,
    input logic [W-1:0] luma_y,
    input logic [W-1:0] luma_w,
    input logic [W-1:0] luma_h,
    input logic [W-1:0] chroma_w,
    input logic [W-1:0] edge_left,
    input logic [W-1:0] edge_right,
    input logic [W-1:0] edge_bottom,
    input logic [W-1:0] scan_x,
    input logic         clamp_flag,
    input logic         done,
    input logic         border_pix
);
    // R1: the aligned window never carries an odd coordinate or size
    assert_even_luma_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (luma_x[0] == 1'b0) && (luma_y[0] == 1'b0) &&
        (luma_w[0] == 1'b0) && (luma_h[0] == 1'b0));

    // R7: a clamp leaves at least one of the two derived borders at zero
    assert_clamp_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_flag |-> (edge_right == '0) || (edge_bottom == '0));

    // R9: done lasts exactly one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8/R9: results move only in the cycle that done is reported
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(luma_w) && $stable(chroma_w) &&
                  $stable(edge_left) && $stable(edge_right) &&
                  $stable(clamp_flag));

    // R10: positions left of the left border are always marked
    assert_left_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_x < edge_left) |-> border_pix);
endmodule

bind vp_border_calc vp_border_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .luma_x      (luma_x),
    .luma_y      (luma_y),
    .luma_w      (luma_w),
    .luma_h      (luma_h),
    .chroma_w    (chroma_w),
    .edge_left   (edge_left),
    .edge_right  (edge_right),
    .edge_bottom (edge_bottom),
    .scan_x      (scan_x),
    .clamp_flag  (clamp_flag),
    .done        (done),
    .border_pix  (border_pix)
);

// File: tb/vp_border_calc_tb.sv
module vp_border_calc_tb;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0, fmt_420 = 1'b0, dbg_confirm = 1'b0;
    logic [W-1:0] vp_x = '0, vp_y = '0, vp_w = '0, vp_h = '0;
    logic [W-1:0] act_w = '0, act_h = '0;
    logic [W-1:0] out_x = '0, out_y = '0, out_w = '0, out_h = '0;
    logic [W-1:0] scan_x = '0, scan_y = '0;
    logic [W-1:0] luma_x, luma_y, luma_w, luma_h;
    logic [W-1:0] chroma_x, chroma_y, chroma_w, chroma_h;
    logic [W-1:0] edge_left, edge_right, edge_top, edge_bottom;
    logic clamp_flag, done, border_pix;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vp_border_calc #(.W(W)) u_dut (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int x, y, w, h, input bit f420, input bit dbg,
                           input int aw, ah, ox, oy, ow, oh);
        vp_x = W'(x); vp_y = W'(y); vp_w = W'(w); vp_h = W'(h);
        fmt_420 = f420; dbg_confirm = dbg;
        act_w = W'(aw); act_h = W'(ah);
        out_x = W'(ox); out_y = W'(oy); out_w = W'(ow); out_h = W'(oh);
    endtask

    // pulse load, wait for the commit edge, check done timing (R9)
    task automatic run_load(input string tag);
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        chk("R9", {tag, " done early"}, int'(done), 0);
        @(negedge clk);
        chk("R9", {tag, " done"}, int'(done), 1);
    endtask

    task automatic expect_vp(input string req, input int x, y, w, h, input bit f420);
        int ex = x & ~1, ey = y & ~1, ew = w & ~1, eh = h & ~1;
        chk("R1", {req, " luma_x"}, int'(luma_x), ex);
        chk("R1", {req, " luma_y"}, int'(luma_y), ey);
        chk("R1", {req, " luma_w"}, int'(luma_w), ew);
        chk("R1", {req, " luma_h"}, int'(luma_h), eh);
        if (f420) begin
            chk("R3", {req, " chroma_x"}, int'(chroma_x), ex / 2);
            chk("R3", {req, " chroma_y"}, int'(chroma_y), ey / 2);
            chk("R3", {req, " chroma_w"}, int'(chroma_w), ew / 2);
            chk("R3", {req, " chroma_h"}, int'(chroma_h), eh / 2);
        end else begin
            chk("R2", {req, " chroma_x"}, int'(chroma_x), ex);
            chk("R2", {req, " chroma_y"}, int'(chroma_y), ey);
            chk("R2", {req, " chroma_w"}, int'(chroma_w), ew);
            chk("R2", {req, " chroma_h"}, int'(chroma_h), eh);
        end
    endtask

    task automatic expect_edges(input string req, input bit dbg,
                                input int aw, ah, ox, oy, ow, oh);
        int r = aw - ox - ow + (dbg ? 2 : 0);
        int b = ah - oy - oh + (dbg ? 2 : 0);
        int cl = (r < 0 || b < 0) ? 1 : 0;
        chk("R4", {req, " left"}, int'(edge_left), ox);
        chk("R4", {req, " top"}, int'(edge_top), oy);
        chk(dbg ? "R6" : "R5", {req, " right"}, int'(edge_right), r < 0 ? 0 : r);
        chk(dbg ? "R6" : "R5", {req, " bottom"}, int'(edge_bottom), b < 0 ? 0 : b);
        chk("R7", {req, " clamp"}, int'(clamp_flag), cl);
    endtask

    task automatic t_reset();
        chk("R11", "reset luma_w", int'(luma_w), 0);
        chk("R11", "reset chroma_h", int'(chroma_h), 0);
        chk("R11", "reset edge_right", int'(edge_right), 0);
        chk("R11", "reset clamp", int'(clamp_flag), 0);
        chk("R11", "reset done", int'(done), 0);
    endtask

    task automatic t_plain_444();
        set_cfg(5, 7, 101, 51, 1'b0, 1'b0, 1920, 1080, 10, 20, 1900, 1050);
        run_load("444");
        expect_vp("444", 5, 7, 101, 51, 1'b0);
        expect_edges("444", 1'b0, 1920, 1080, 10, 20, 1900, 1050);
        @(negedge clk);
        chk("R9", "444 done drop", int'(done), 0);
    endtask

    task automatic t_border_pix();
        // borders from t_plain_444: left 10, right 10, top 20, bottom 10
        scan_y = 500; scan_x = 9;    #1 chk("R10", "x=9",    int'(border_pix), 1);
        scan_x = 10;                 #1 chk("R10", "x=10",   int'(border_pix), 0);
        scan_x = 1909;               #1 chk("R10", "x=1909", int'(border_pix), 0);
        scan_x = 1910;               #1 chk("R10", "x=1910", int'(border_pix), 1);
        scan_x = 500; scan_y = 19;   #1 chk("R10", "y=19",   int'(border_pix), 1);
        scan_y = 1069;               #1 chk("R10", "y=1069", int'(border_pix), 0);
        scan_y = 1070;               #1 chk("R10", "y=1070", int'(border_pix), 1);
        scan_x = 0; scan_y = 0;
    endtask

    task automatic t_420_dbg();
        set_cfg(9, 3, 200, 99, 1'b1, 1'b1, 1920, 1080, 0, 0, 1920, 1080);
        run_load("420");
        expect_vp("420", 9, 3, 200, 99, 1'b1);
        expect_edges("420", 1'b1, 1920, 1080, 0, 0, 1920, 1080);
    endtask

    task automatic t_clamp();
        set_cfg(0, 0, 64, 64, 1'b0, 1'b0, 1920, 1080, 100, 0, 1900, 1080);
        run_load("clamp");
        expect_edges("clamp", 1'b0, 1920, 1080, 100, 0, 1900, 1080);
        set_cfg(0, 0, 64, 64, 1'b0, 1'b0, 640, 480, 0, 30, 640, 460);
        run_load("clamp2");
        expect_edges("clamp2", 1'b0, 640, 480, 0, 30, 640, 460);
    endtask

    task automatic t_zero_size();
        // previous window is 64x64 at origin, 4:4:4
        set_cfg(20, 20, 1, 40, 1'b0, 1'b0, 800, 600, 5, 6, 700, 500);
        run_load("zero");
        chk("R8", "zero luma_w held", int'(luma_w), 64);
        chk("R8", "zero luma_x held", int'(luma_x), 0);
        chk("R8", "zero chroma_h held", int'(chroma_h), 64);
        expect_edges("zero", 1'b0, 800, 600, 5, 6, 700, 500);
    endtask

    task automatic t_busy_load();
        set_cfg(40, 40, 80, 80, 1'b0, 1'b0, 1000, 1000, 10, 10, 900, 900);
        @(negedge clk); load = 1'b1;
        @(negedge clk);             // now in calc
        set_cfg(100, 100, 300, 300, 1'b0, 1'b0, 1000, 1000, 50, 50, 800, 800);
        @(negedge clk);             // done; load still high, ignored
        load = 1'b0;
        chk("R9", "busy done", int'(done), 1);
        repeat (3) @(negedge clk);
        chk("R9", "busy no rerun", int'(done), 0);
        chk("R9", "busy luma_w", int'(luma_w), 80);
        chk("R9", "busy edge_left", int'(edge_left), 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_plain_444();
        t_border_pix();
        t_420_dbg();
        t_clamp();
        t_zero_size();
        t_busy_load();
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule